// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Read DMA

This block streams pixel words out of memory into a display input FIFO so that the panel refresh never waits on software. It reads from one frame buffer, or from two buffers used in turn. Each buffer is set by the address of its first word and the address of its last word. In two-buffer mode, software can rewrite the idle buffer while the engine is reading the other one.

The engine asks memory for a burst only when the FIFO reports enough free words to take the whole burst. Only one burst is in flight at a time. Each returned word goes straight into the FIFO write port. Near the end of a buffer, fewer words may remain than one burst holds. In that case the engine reads single words until it reaches the last address, and then wraps to the start of the next buffer.

Status bits record each completed buffer and any FIFO read that finds the FIFO empty. Each status bit is cleared by writing 1 to it. A single interrupt line is raised from the status bits that are enabled.

Top module: `pp_fb_dma`

## Requirements
- R1: After reset `rdReq`, `fifoWrEn` and `irq` are low and `status` is 4'b0000.
- R2: With `cfgDual`=0, every buffer pass reads from `fb0Base` to `fb0Ceil`, and the next pass starts again at `fb0Base`. The values of `fb1Base` and `fb1Ceil` have no effect on any request.
- R3: With `cfgDual`=1, the engine finishes one buffer and then starts at the base of the other buffer, so buffer 0 and buffer 1 alternate.
- R4: The burst length is 2^`cfgBurstSel` words for `cfgBurstSel` 0 to 4, and 16 words for `cfgBurstSel` 5 to 7. `rdLen` gives the word count of the request. The address advances by 4 bytes per word. The ceiling address is the last word read, inclusive.
- R5: When fewer words remain up to the ceiling than one burst holds, each remaining word is read with its own request with `rdLen`=1.
- R6: `rdReq` is high only when `fifoSpace` is at least `rdLen`. While it is smaller, no request is made.
- R7: With `cfgEnable` low, no request is made. When `cfgEnable` is cleared, the burst in flight still delivers all its words and no new request follows. When the engine is enabled again, the first request starts at `fb0Base`.
- R8: Each word returned with `rdValid` is written to the FIFO in the same cycle, as `fifoWrEn` with `fifoWrData` equal to `rdData`.
- R9: When a buffer is completely read, the engine sets a status bit for that buffer: bit 0 for buffer 0, bit 1 for buffer 1. It also sets bit 2 (done) in either case. These bits are set whatever `irqEn` holds. A 1 in `statClear` clears the matching bit. A set in the same cycle wins over a clear.
- R10: A pulse on `fifoEmptyRd` sets status bit 3 (underflow). The bit stays set until it is cleared through `statClear`.
- R11: `irq` is high exactly when some bit of `status` is 1 and the bit of `irqEn` at the same position is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Run enable |
| cfgDual | input | 1 | 1 = alternate two buffers, 0 = buffer 0 only |
| cfgBurstSel | input | 3 | Burst length select (log2 of words, capped at 16) |
| fb0Base | input | 32 | First word address of buffer 0 |
| fb0Ceil | input | 32 | Last word address of buffer 0 |
| fb1Base | input | 32 | First word address of buffer 1 |
| fb1Ceil | input | 32 | Last word address of buffer 1 |
| irqEn | input | 4 | Per-status-bit interrupt enables |
| statClear | input | 4 | Write-1-to-clear pulses for status bits |
| rdReq | output | 1 | Read request valid |
| rdAddr | output | 32 | Byte address of the first word of the request |
| rdLen | output | 5 | Words in the request |
| rdGnt | input | 1 | Memory accepts the request |
| rdValid | input | 1 | Returned word valid |
| rdData | input | 32 | Returned word |
| fifoSpace | input | 6 | Free words in the display FIFO |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 32 | FIFO write word |
| fifoEmptyRd | input | 1 | FIFO was read while empty |
| status | output | 4 | {underflow, done, eof1, eof0} |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the rules that hold for each request: room in the FIFO, request only while enabled, a request length that is a power of two, an aligned address, FIFO writes only on returned data, status bits that stay set until cleared, underflow capture, and an interrupt only from a set status bit. Only the bench scenarios show the address order of whole passes. These include the wrap in single mode, the alternation in dual mode, the burst-to-single-word tail, the per-buffer done flags, the restart at buffer 0 after the engine is enabled again, and the burst that drains after the enable is cleared. The bench computes all of these with its own model of the walk through each buffer.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA} dmaState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadFirst;  // point at base of buffer 0
    logic accept;     // request granted, latch its length
    logic beat;       // one data word returned
    logic burstEnd;   // last word of current burst returned
  } dmaStrobe_t;

  localparam int STAT_W = 4;
  localparam int ST_EOF0 = 0;
  localparam int ST_EOF1 = 1;
  localparam int ST_DONE = 2;
  localparam int ST_UNDR = 3;
endpackage

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
#(
  parameter int LEN_W   = 5,
  parameter int SPACE_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [SPACE_W-1:0] fifoSpace,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             lastBeat,
  input  logic             rdGnt,
  input  logic             rdValid,
  output logic             rdReq,
  output logic             fifoWrEn,
  output dmaStrobe_t       stb
);
  dmaState_t state, stateNx;
  logic roomOk;

  assign roomOk = fifoSpace >= SPACE_W'(reqLen);

  always_comb begin
    stateNx  = state;
    stb      = '0;
    rdReq    = 1'b0;
    fifoWrEn = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cfgEnable) begin
          stb.loadFirst = 1'b1;
          stateNx       = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!cfgEnable) begin
          stateNx = ST_IDLE;
        end else begin
          rdReq = roomOk;
          if (roomOk && rdGnt) begin
            stb.accept = 1'b1;
            stateNx    = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (rdValid) begin
          fifoWrEn = 1'b1;
          stb.beat = 1'b1;
          if (lastBeat) begin
            stb.burstEnd = 1'b1;
            stateNx      = cfgEnable ? ST_REQ : ST_IDLE;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end
endmodule

// File: rtl/pp_dma_path.sv
module pp_dma_path
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 16,
  parameter int LEN_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        stb,
  input  logic              cfgDual,
  input  logic [2:0]        cfgBurstSel,
  input  logic [ADDR_W-1:0] fb0Base,
  input  logic [ADDR_W-1:0] fb0Ceil,
  input  logic [ADDR_W-1:0] fb1Base,
  input  logic [ADDR_W-1:0] fb1Ceil,
  input  logic [STAT_W-1:0] irqEn,
  input  logic [STAT_W-1:0] statClear,
  input  logic              fifoEmptyRd,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic              lastBeat,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam int MAX_SEL = $clog2(MAX_BURST);

  logic              curBuf;
  logic [LEN_W-1:0]  beatCnt;
  logic [LEN_W-1:0]  burstLen;
  logic              endsBuf;
  logic [ADDR_W-1:0] ceilNow;
  logic [ADDR_W-1:0] wordsLeft;
  logic [2:0]        selEff;
  logic [LEN_W-1:0]  burstWords;
  logic              nextBuf;
  logic [STAT_W-1:0] setVec;
  logic              frameEnd;

  assign selEff     = (int'(cfgBurstSel) > MAX_SEL) ? 3'(MAX_SEL) : cfgBurstSel;
  assign burstWords = LEN_W'(1) << selEff;
  assign ceilNow    = curBuf ? fb1Ceil : fb0Ceil;
  assign wordsLeft  = ((ceilNow - curAddr) >> 2) + ADDR_W'(1);
  assign reqLen     = (wordsLeft >= ADDR_W'(burstWords)) ? burstWords : LEN_W'(1);
  assign lastBeat   = (beatCnt == LEN_W'(1));
  assign nextBuf    = cfgDual ? ~curBuf : 1'b0;
  assign frameEnd   = stb.burstEnd && endsBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curBuf   <= 1'b0;
      beatCnt  <= '0;
      burstLen <= '0;
      endsBuf  <= 1'b0;
    end else begin
      if (stb.loadFirst) begin
        curAddr <= fb0Base;
        curBuf  <= 1'b0;
      end
      if (stb.accept) begin
        burstLen <= reqLen;
        beatCnt  <= reqLen;
        endsBuf  <= (ADDR_W'(reqLen) == wordsLeft);
      end else if (stb.beat) begin
        beatCnt <= beatCnt - LEN_W'(1);
      end
      if (stb.burstEnd) begin
        if (endsBuf) begin
          curBuf  <= nextBuf;
          curAddr <= nextBuf ? fb1Base : fb0Base;
        end else begin
          curAddr <= curAddr + (ADDR_W'(burstLen) << 2);
        end
      end
    end
  end

  assign setVec[ST_EOF0] = frameEnd && !curBuf;
  assign setVec[ST_EOF1] = frameEnd && curBuf;
  assign setVec[ST_DONE] = frameEnd;
  assign setVec[ST_UNDR] = fifoEmptyRd;

  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_stat
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            status[gi] <= 1'b0;
        else if (setVec[gi])  status[gi] <= 1'b1;
        else if (statClear[gi]) status[gi] <= 1'b0;
      end
    end
  endgenerate

  assign irq = |(status & irqEn);
endmodule

// File: rtl/pp_fb_dma.sv
module pp_fb_dma
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 16,
  parameter int SPACE_W   = 6,
  localparam int LEN_W    = $clog2(MAX_BURST) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgDual,
  input  logic [2:0]        cfgBurstSel,
  input  logic [ADDR_W-1:0] fb0Base,
  input  logic [ADDR_W-1:0] fb0Ceil,
  input  logic [ADDR_W-1:0] fb1Base,
  input  logic [ADDR_W-1:0] fb1Ceil,
  input  logic [3:0]        irqEn,
  input  logic [3:0]        statClear,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LEN_W-1:0]  rdLen,
  input  logic              rdGnt,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic [SPACE_W-1:0] fifoSpace,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  input  logic              fifoEmptyRd,
  output logic [3:0]        status,
  output logic              irq
);
  dmaStrobe_t stb;
  logic       lastBeat;

  pp_dma_ctrl #(.LEN_W(LEN_W), .SPACE_W(SPACE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .fifoSpace(fifoSpace),
    .reqLen(rdLen), .lastBeat(lastBeat), .rdGnt(rdGnt), .rdValid(rdValid),
    .rdReq(rdReq), .fifoWrEn(fifoWrEn), .stb(stb)
  );

  pp_dma_path #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgDual(cfgDual), .cfgBurstSel(cfgBurstSel),
    .fb0Base(fb0Base), .fb0Ceil(fb0Ceil), .fb1Base(fb1Base), .fb1Ceil(fb1Ceil),
    .irqEn(irqEn), .statClear(statClear), .fifoEmptyRd(fifoEmptyRd),
    .curAddr(rdAddr), .reqLen(rdLen), .lastBeat(lastBeat),
    .status(status), .irq(irq)
  );

  assign fifoWrData = rdData;
endmodule

// File: rtl/pp_fb_dma_chk.sv
module pp_fb_dma_chk #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 5,
  parameter int SPACE_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgEnable,
  input logic               rdReq,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [LEN_W-1:0]   rdLen,
  input logic               rdValid,
  input logic [SPACE_W-1:0] fifoSpace,
  input logic               fifoWrEn,
  input logic               fifoEmptyRd,
  input logic [3:0]         statClear,
  input logic [3:0]         status,
  input logic               irq
);
  p_req_fits_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (fifoSpace >= SPACE_W'(rdLen)));

  p_req_needs_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> cfgEnable);

  p_len_pow2_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> ($countones(rdLen) == 1));

  p_addr_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdAddr[1:0] == 2'b00));

  p_wr_on_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> rdValid);

  p_underflow_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmptyRd |=> status[3]);

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (status != 4'b0000));

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_sticky
      p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
        (status[gi] && !statClear[gi]) |=> status[gi]);
    end
  endgenerate
endmodule

bind pp_fb_dma pp_fb_dma_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SPACE_W(SPACE_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .rdReq(rdReq), .rdAddr(rdAddr),
  .rdLen(rdLen), .rdValid(rdValid), .fifoSpace(fifoSpace), .fifoWrEn(fifoWrEn),
  .fifoEmptyRd(fifoEmptyRd), .statClear(statClear), .status(status), .irq(irq)
);

// File: tb/sim_pp_fb_dma.sv
module sim_pp_fb_dma;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0, cfgDual = 1'b0;
  logic [2:0]  cfgBurstSel = 3'd0;
  logic [31:0] fb0Base = '0, fb0Ceil = '0, fb1Base = '0, fb1Ceil = '0;
  logic [3:0]  irqEn = '0, statClear = '0;
  logic        rdReq, rdGnt, rdValid;
  logic [31:0] rdAddr, rdData;
  logic [4:0]  rdLen;
  logic [5:0]  fifoSpace = 6'd32;
  logic        fifoWrEn, fifoEmptyRd = 1'b0, irq;
  logic [31:0] fifoWrData;
  logic [3:0]  status;

  int total = 0, bad = 0;
  int reqCount = 0, wrCount = 0, wrBad = 0, beatsLeft = 0;
  logic [31:0] beatAddr;
  logic [31:0] logAddr [0:255];
  int          logLen  [0:255];

  always #10 clk = ~clk;

  pp_fb_dma u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgDual(cfgDual),
    .cfgBurstSel(cfgBurstSel), .fb0Base(fb0Base), .fb0Ceil(fb0Ceil),
    .fb1Base(fb1Base), .fb1Ceil(fb1Ceil), .irqEn(irqEn), .statClear(statClear),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdLen(rdLen), .rdGnt(rdGnt),
    .rdValid(rdValid), .rdData(rdData), .fifoSpace(fifoSpace),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .fifoEmptyRd(fifoEmptyRd),
    .status(status), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder: grants at negedge, returns words (data = address) on later negedges
  initial begin
    rdGnt = 1'b0; rdValid = 1'b0; rdData = '0; beatAddr = '0;
    forever begin
      @(negedge clk);
      rdGnt = 1'b0; rdValid = 1'b0;
      if (beatsLeft > 0) begin
        rdValid = 1'b1; rdData = beatAddr;
        beatAddr += 4; beatsLeft--;
        #1;
        if (fifoWrEn && fifoWrData == rdData) wrCount++;
        else wrBad++;
      end else if (rdReq) begin
        rdGnt = 1'b1;
        if (reqCount < 256) begin
          logAddr[reqCount] = rdAddr;
          logLen[reqCount]  = int'(rdLen);
        end
        reqCount++;
        beatsLeft = int'(rdLen);
        beatAddr  = rdAddr;
      end
    end
  end

  task automatic drive_edge();
    @(posedge clk); #2;
  endtask

  task automatic clear_all();
    drive_edge(); statClear = 4'hF;
    drive_edge(); statClear = 4'h0;
  endtask

  // independent model of the buffer walk; checks logged requests
  task automatic check_walk(input bit dual, input int sel, input string tag,
                            output bit seen0, output bit seen1);
    int B, left, len, sumLen;
    logic [31:0] eAddr, b, c;
    bit eBuf;
    B = 1 << ((sel > 4) ? 4 : sel);
    eAddr = fb0Base; eBuf = 1'b0; seen0 = 0; seen1 = 0; sumLen = 0;
    for (int k = 0; k < reqCount; k++) begin
      c = eBuf ? fb1Ceil : fb0Ceil;
      left = int'((c - eAddr) >> 2) + 1;
      len = (left >= B) ? B : 1;
      chk(logAddr[k] == eAddr, tag, logAddr[k], eAddr);
      chk(logLen[k] == len, tag, logLen[k], len);
      sumLen += len;
      if (len == left) begin
        if (eBuf) seen1 = 1; else seen0 = 1;
        eBuf = dual ? ~eBuf : 1'b0;
        b = eBuf ? fb1Base : fb0Base;
        eAddr = b;
      end else begin
        eAddr += 32'(len * 4);
      end
    end
    // R8: every word reached the FIFO unchanged; R7: burst in flight drained
    chk(wrBad == 0, "R8 fifo write data", wrBad, 0);
    chk(wrCount == sumLen, "R7 drain after disable", wrCount, sumLen);
  endtask

  task automatic run_case(input bit dual, input int sel, input logic [31:0] b0, input int w0,
                          input logic [31:0] b1, input int w1, input int n, input string tag);
    bit s0, s1;
    drive_edge();
    cfgDual = dual; cfgBurstSel = 3'(sel);
    fb0Base = b0; fb0Ceil = b0 + 32'((w0 - 1) * 4);
    fb1Base = b1; fb1Ceil = b1 + 32'((w1 - 1) * 4);
    clear_all();
    reqCount = 0; wrCount = 0; wrBad = 0;
    drive_edge(); cfgEnable = 1'b1;
    while (reqCount < n) @(negedge clk);
    drive_edge(); cfgEnable = 1'b0;
    repeat (40) @(negedge clk);
    #2;
    chk(rdReq == 1'b0, "R7 no request when disabled", rdReq, 0);
    check_walk(dual, sel, tag, s0, s1);
    chk(status[0] == s0, "R9 eof0", status[0], s0);
    chk(status[1] == s1, "R9 eof1", status[1], s1);
    chk(status[2] == (s0 | s1), "R9 done", status[2], s0 | s1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(rdReq == 0, "R1 rdReq", rdReq, 0);
    chk(fifoWrEn == 0, "R1 fifoWrEn", fifoWrEn, 0);
    chk(status == 0, "R1 status", status, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    drive_edge(); rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(reqCount == 0, "R7 idle while disabled", reqCount, 0);

    // R2 R5: single buffer, 10 words, bursts of 4 -> 4,4,1,1 then wrap; fb1 is junk
    run_case(1'b0, 2, 32'h1000, 10, 32'hDEAD0000, 3, 12, "R2 R5 single wrap");
    // R3: dual, 5 and 4 words, burst 2
    run_case(1'b1, 1, 32'h2000, 5, 32'h3000, 4, 10, "R3 dual alternate");
    // R3 R4: one-word buffers alternate on each request (inclusive ceiling)
    run_case(1'b1, 3, 32'h5000, 1, 32'h6000, 1, 6, "R4 R3 one-word buffers");
    // R4: sweep of burst selects incl. clamp
    for (int s = 0; s <= 7; s++)
      run_case(1'b0, s, 32'h4000, 20, 32'h0, 1, 8, "R4 burst select sweep");
    // R7: re-enable restarts at buffer 0 after a partial dual run
    run_case(1'b1, 0, 32'h7000, 3, 32'h8000, 3, 4, "R7 first pass");
    run_case(1'b1, 0, 32'h7000, 3, 32'h8000, 3, 2, "R7 restart at fb0");

    // R9 R11: status set while irq disabled, then gated by irqEn
    run_case(1'b1, 1, 32'h2000, 2, 32'h3000, 2, 4, "R3 short dual");
    #1;
    chk(status[2:0] == 3'b111, "R9 set with irq disabled", status, 7);
    chk(irq == 0, "R11 irq off when masked", irq, 0);
    drive_edge(); irqEn = 4'b0010;
    @(negedge clk); #2;
    chk(irq == 1, "R11 irq from eof1", irq, 1);
    drive_edge(); statClear = 4'b0010;
    drive_edge(); statClear = 4'b0000;
    @(negedge clk); #2;
    chk(status == 4'b0101, "R9 w1c one bit", status, 5);
    chk(irq == 0, "R11 irq drops after clear", irq, 0);

    // R10 underflow
    clear_all();
    drive_edge(); irqEn = 4'b1000; fifoEmptyRd = 1'b1;
    drive_edge(); fifoEmptyRd = 1'b0;
    repeat (3) @(negedge clk); #2;
    chk(status == 4'b1000, "R10 underflow sticky", status, 8);
    chk(irq == 1, "R11 underflow irq", irq, 1);
    clear_all();
    @(negedge clk); #2;
    chk(status == 0, "R10 underflow cleared", status, 0);
    drive_edge(); irqEn = 4'b0000;

    // R6: not enough FIFO room holds the request
    drive_edge();
    cfgDual = 1'b0; cfgBurstSel = 3'd2; fb0Base = 32'h9000; fb0Ceil = 32'h9000 + 32'd28;
    fifoSpace = 6'd3; reqCount = 0; wrCount = 0; wrBad = 0;
    drive_edge(); cfgEnable = 1'b1;
    repeat (10) @(negedge clk); #2;
    chk(reqCount == 0, "R6 held on low space", reqCount, 0);
    chk(rdReq == 0, "R6 rdReq low", rdReq, 0);
    drive_edge(); fifoSpace = 6'd4;
    repeat (4) @(negedge clk); #2;
    chk(reqCount == 1, "R6 issue once room", reqCount, 1);
    chk(logLen[0] == 4, "R6 burst length", logLen[0], 4);
    drive_edge(); cfgEnable = 1'b0; fifoSpace = 6'd32;
    repeat (20) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule